// File: doc/BRIEF.md
# Three-Level SAR Capacitor Switching Controller

This block sequences a successive-approximation conversion for a differential capacitive DAC. Each capacitor's bottom plate can sit at one of three levels: the high reference, the low reference, or common mode. A conversion starts from all plates at common mode. The controller then uses one comparator decision per clock cycle. The first decision fixes the polarity of the most significant capacitor. Each later cycle drives the next capacitor to that same polarity, whatever the comparator says.

When a later decision disagrees with the first one, the controller does not flip the previous capacitor to the opposite reference. It returns that capacitor to common mode. As a result, no plate ever takes the polarity opposite to the first decision, and each plate makes at most one trip out to a reference and one trip back. After the last decision the controller publishes a binary code, pulses a done flag for one cycle and parks every plate at common mode.

Top module: `sarEmcsTop`

## Requirements
- R1: A synchronous active-high reset puts every capacitor drive at common mode (2'b00) and clears done. Reset is also honoured in the middle of a conversion.
- R2: In the first decision cycle, capacitor 0 (bus bits [1:0], the heaviest one) is driven high (2'b10) if the comparator reads 1 and low (2'b01) if it reads 0. That comparator value is the first decision, b1.
- R3: In decision cycle k (k = 1..N-1), capacitor k (bus bits [2k+1:2k]) is driven to b1's polarity regardless of the comparator.
- R4: In decision cycle k ≥ 1, a comparator value different from b1 returns capacitor k-1 to common mode. An equal value leaves capacitor k-1 at its level.
- R5: The code 2'b11 never appears on any capacitor. No capacitor ever holds the polarity opposite to b1, so high and low drives never coexist on the bus.
- R6: Within one conversion, each capacitor goes from common mode to a reference at most once and from a reference back to common mode at most once. At most one capacitor leaves common mode per cycle.
- R7: A start strobe sampled while idle begins a conversion. The N decisions are taken on the N following clock edges. On the last of those edges, done rises for exactly one cycle and every drive returns to common mode.
- R8: The result code holds b1 in its MSB. The bit at position N-2-i (i = 0..N-2) is b1 if capacitor i ended the last decision at b1's polarity, and NOT b1 if it ended at common mode. With an ideal comparator the code equals the input code.
- R9: A start strobe sampled during a conversion is ignored: the conversion in flight finishes at its original time with its original result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a conversion when idle |
| comp | input | 1 | Comparator decision, 1 when the residue is positive |
| capDrive | output | 2*N | Two bits per capacitor: 00 common mode, 01 low reference, 10 high reference |
| done | output | 1 | One-cycle pulse when the code is valid |
| code | output | N | Binary conversion result, held until the next done |

## Verification
The hardest behaviour to reach is the reset-to-common-mode path in the middle of a conversion. It depends on a comparator that disagrees with the first decision at a given step, and that in turn depends on how the residue evolves. The bench closes this loop with an inline ideal comparator that reads the drive bus and computes the residue. It then sweeps every input code, so every pattern of agreement and disagreement is produced, including the alternating patterns that reset every capacitor. Random start strobes injected mid-conversion and a mid-conversion reset cover the control corner cases.

// File: rtl/sarEmcsPkg.sv
package sarEmcsPkg;

  typedef enum logic [1:0] {
    DRV_CM = 2'b00,
    DRV_LO = 2'b01,
    DRV_HI = 2'b10
  } drive_e;

  typedef struct packed {
    logic firstBit;
    logic laterBit;
    logic lastBit;
  } strobe_t;

endpackage

// File: rtl/sarEmcsCtrl.sv
module sarEmcsCtrl
  import sarEmcsPkg::*;
#(
  parameter int N    = 10,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output strobe_t         strb,
  output logic [IDXW-1:0] stepIdx
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(N - 1);

  logic busyQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      busyQ   <= 1'b0;
      stepIdx <= '0;
    end else if (!busyQ) begin
      if (start) begin
        busyQ   <= 1'b1;
        stepIdx <= '0;
      end
    end else begin
      if (stepIdx == LAST_IDX) begin
        busyQ   <= 1'b0;
        stepIdx <= '0;
      end else begin
        stepIdx <= stepIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strb.firstBit = busyQ && (stepIdx == '0);
    strb.laterBit = busyQ && (stepIdx != '0);
    strb.lastBit  = busyQ && (stepIdx == LAST_IDX);
  end

endmodule

// File: rtl/sarEmcsDatapath.sv
module sarEmcsDatapath
  import sarEmcsPkg::*;
#(
  parameter int N    = 10,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            comp,
  input  strobe_t         strb,
  input  logic [IDXW-1:0] stepIdx,
  output logic [2*N-1:0]  capDrive,
  output logic [N-1:0]    code,
  output logic            done
);

  drive_e   capQ   [N];
  drive_e   capNxt [N];
  logic     b1Q;
  logic     curB1;
  drive_e   pol;
  logic [N-1:0] codeNxt;

  // First decision is live in its own cycle, registered afterwards
  assign curB1 = strb.firstBit ? comp : b1Q;
  assign pol   = curB1 ? DRV_HI : DRV_LO;

  for (genvar i = 0; i < N; i++) begin : g_cap
    always_comb begin
      capNxt[i] = capQ[i];
      if (strb.firstBit && (i == 0))
        capNxt[i] = pol;
      if (strb.laterBit && (int'(stepIdx) == i))
        capNxt[i] = pol;
      if (strb.laterBit && (int'(stepIdx) == i + 1) && (comp != curB1))
        capNxt[i] = DRV_CM;
    end

    always_ff @(posedge clk) begin
      if (rst || strb.lastBit) capQ[i] <= DRV_CM;
      else                     capQ[i] <= capNxt[i];
    end

    assign capDrive[2*i +: 2] = capQ[i];

    if (i < N - 1) begin : g_bit
      assign codeNxt[N-2-i] = (capNxt[i] == pol) ? curB1 : ~curB1;
    end
  end

  assign codeNxt[N-1] = curB1;

  always_ff @(posedge clk) begin
    if (rst) begin
      b1Q  <= 1'b0;
      code <= '0;
      done <= 1'b0;
    end else begin
      done <= strb.lastBit;
      if (strb.firstBit) b1Q  <= comp;
      if (strb.lastBit)  code <= codeNxt;
    end
  end

endmodule

// File: rtl/sarEmcsTop.sv
module sarEmcsTop
  import sarEmcsPkg::*;
#(
  parameter int N = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           comp,
  output logic [2*N-1:0] capDrive,
  output logic           done,
  output logic [N-1:0]   code
);

  localparam int IDXW = (N > 1) ? $clog2(N) : 1;

  strobe_t         strb;
  logic [IDXW-1:0] stepIdx;

  sarEmcsCtrl #(.N(N), .IDXW(IDXW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .strb    (strb),
    .stepIdx (stepIdx)
  );

  sarEmcsDatapath #(.N(N), .IDXW(IDXW)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .comp     (comp),
    .strb     (strb),
    .stepIdx  (stepIdx),
    .capDrive (capDrive),
    .code     (code),
    .done     (done)
  );

endmodule

// File: rtl/sarEmcsChk.sv
module sarEmcsChk #(
  parameter int N = 10
) (
  input logic           clk,
  input logic           rst,
  input logic [2*N-1:0] capDrive,
  input logic           done
);

  logic [N-1:0] hiBits;
  logic [N-1:0] loBits;
  logic [N-1:0] active;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      hiBits[i] = capDrive[2*i+1];
      loBits[i] = capDrive[2*i];
    end
    active = hiBits | loBits;
  end

  // R5
  no_illegal_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (hiBits & loBits) == '0);

  // R5
  no_mixed_polarity_chk: assert property (@(posedge clk) disable iff (rst)
    !((|hiBits) && (|loBits)));

  // R6
  one_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(active & ~$past(active)) <= 1);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (capDrive == '0));

endmodule

bind sarEmcsTop sarEmcsChk #(.N(N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .capDrive (capDrive),
  .done     (done)
);

// File: tb/tb_sarEmcsTop.sv
module tb_sarEmcsTop;

  localparam int N = 10;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic           comp;
  logic [2*N-1:0] capDrive;
  logic           done;
  logic [N-1:0]   code;

  int nChecks = 0;
  int nFail   = 0;
  int curX    = 0;

  always #10 clk = ~clk;

  sarEmcsTop #(.N(N)) dut (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .comp     (comp),
    .capDrive (capDrive),
    .done     (done),
    .code     (code)
  );

  // Ideal comparator: sign of input minus DAC level, in half-LSB units
  function automatic logic compModel(int x, logic [2*N-1:0] d);
    longint v = 0;
    for (int i = 0; i < N; i++) begin
      if (d[2*i +: 2] == 2'b10) v += longint'(1) << (N - 1 - i);
      if (d[2*i +: 2] == 2'b01) v -= longint'(1) << (N - 1 - i);
    end
    return (longint'(2 * x + 1) - (longint'(1) << N) - v) > 0;
  endfunction

  assign comp = compModel(curX, capDrive);

  task automatic chk(bit ok, string req, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runConv(int x, bit inject);
    int injAt;
    logic b1 = 1'b0;
    logic cmp;
    logic [1:0] pol = 2'b00;
    logic [1:0] oldD, newD;
    logic [2*N-1:0] prevBus;
    int riseCnt [N];
    int fallCnt [N];
    bit opp = 0;
    bit multi = 0;
    bit onTime = 0;
    for (int i = 0; i < N; i++) begin riseCnt[i] = 0; fallCnt[i] = 0; end
    curX  = x;
    injAt = inject ? int'($urandom_range(N - 1, 0)) : -1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(capDrive == '0 && done == 1'b0, "R7", capDrive, 0);
    prevBus = capDrive;
    for (int k = 0; k < N; k++) begin
      cmp = comp;
      if (k == injAt) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (k == 0) b1 = cmp;
      pol = b1 ? 2'b10 : 2'b01;
      for (int i = 0; i < N; i++) begin
        oldD = prevBus[2*i +: 2];
        newD = capDrive[2*i +: 2];
        if (oldD == 2'b00 && newD != 2'b00) riseCnt[i]++;
        if (oldD != 2'b00 && newD == 2'b00) fallCnt[i]++;
        if (newD != 2'b00 && newD != pol) opp = 1;
        if (riseCnt[i] > 1 || fallCnt[i] > 1) multi = 1;
      end
      if (k < N - 1) begin
        chk(capDrive[2*k +: 2] == pol, (k == 0) ? "R2" : "R3",
            capDrive[2*k +: 2], pol);
        if (k > 0)
          chk(capDrive[2*(k-1) +: 2] == ((cmp == b1) ? pol : 2'b00), "R4",
              capDrive[2*(k-1) +: 2], (cmp == b1) ? pol : 2'b00);
        chk(done == 1'b0, "R7", done, 0);
      end else begin
        onTime = (done == 1'b1);
        chk(onTime, "R7", done, 1);
        chk(code == N'(x), "R8", code, x);
        chk(capDrive == '0, "R7", capDrive, 0);
      end
      prevBus = capDrive;
    end
    chk(!opp, "R5", opp, 0);
    chk(!multi, "R6", multi, 0);
    if (inject) chk(onTime && code == N'(x), "R9", code, x);
    @(negedge clk);
    chk(done == 1'b0, "R7", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7219));
    repeat (3) @(negedge clk);
    chk(capDrive == '0 && done == 1'b0, "R1", capDrive, 0);
    rst = 1'b0;
    @(negedge clk);

    // Directed corners: extremes, mid-scale neighbours, alternating codes
    runConv(0, 0);
    runConv((1 << N) - 1, 0);
    runConv(1 << (N - 1), 0);
    runConv((1 << (N - 1)) - 1, 0);
    runConv(10'h2AA, 0);
    runConv(10'h155, 1);

    // Mid-conversion reset (R1), then recovery
    curX  = 10'h3C3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(capDrive == '0 && done == 1'b0, "R1", capDrive, 0);
    rst = 1'b0;
    @(negedge clk);
    runConv(10'h3C3, 0);

    // Full sweep of every input code, with random ignored start strobes
    for (int x = 0; x < (1 << N); x++) runConv(x, ($urandom_range(3, 0) == 0));

    // Random codes
    for (int j = 0; j < 200; j++) runConv(int'($urandom_range((1 << N) - 1, 0)), 1);

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule